// File: doc/BRIEF.md
# Bulk IN Endpoint Stall and Status Control

This block keeps the control and status state of one bulk IN endpoint in a USB device controller. On the protocol side it receives IN-token arrivals, the end of each transaction with the host's acknowledge, and transmit FIFO underrun events. For every IN token it returns a handshake decision: send data, NAK or STALL. On the CPU side it presents one small register that carries a packet-done flag, an underrun flag, a stall-issued flag, a stall-request bit and the current data toggle.

A stall request does not take effect in the middle of a transaction. The block enters the stall state only once the endpoint is idle, and it raises the stall-issued flag at that point. It leaves the stall state only after software has cleared both the request bit and the stall-issued flag. Leaving the stall state is also the only way to bring the data toggle back to DATA0. When software clears the stall-issued flag, the block sends a one-cycle flush request to the transmit FIFO. When the FIFO underruns during a packet, the block signals a bad CRC so that the host drops the packet.

Top module: `in_ep_ctl`

## Requirements
- R1: After reset the register reads all zero, `data_pid` is 0, and `hs_valid`, `crc_bad` and `fifo_flush` are low.
- R2: One cycle after an IN token, `hs_valid` pulses for one cycle with `hs_code` 1 (data) if `pkt_ready` is high and the endpoint is not stalling, or 2 (NAK) if `pkt_ready` is low.
- R3: Register bit 3 is the stall request, a plain read/write bit. While bit 3 or bit 2 reads 1, every IN token is answered with `hs_code` 3 (STALL).
- R4: While a data transaction is open (from the data handshake until `txn_end`), a stall request does not enter the stall state. Entry happens on the first idle cycle after that, and bit 2 (stall issued) is set at entry. When the endpoint is idle, bit 2 reads 1 two cycles after the write that sets bit 3.
- R5: Bit 2 is write-1-to-clear; writing 0 to it leaves it unchanged. A write that clears it raises `fifo_flush` for exactly one cycle, one cycle after the write. A STALL handshake sets bit 2 again.
- R6: The stall state ends one cycle after both bit 3 and bit 2 read 0. Leaving it resets the data toggle (bit 4 and `data_pid`) to 0. While bit 2 is still 1, tokens keep getting STALL.
- R7: The data toggle flips only on `txn_end` with `txn_ack` high for a packet that did not underrun. NAK, STALL and underrun-corrupted packets leave it unchanged.
- R8: An `underrun` pulse during an open transaction drives `crc_bad` high for exactly one cycle, one cycle later.
- R9: Bit 1 (underrun) reads 1 only while bit 0 is also 1. It is cleared together with bit 0.
- R10: Bit 0 (packet done) is set by `txn_end` of an open transaction and is write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | CPU register write strobe |
| reg_wdata | input | REG_W | CPU write data |
| reg_rdata | output | REG_W | Register contents |
| tok_in | input | 1 | IN token arrived (one-cycle pulse) |
| pkt_ready | input | 1 | Transmit FIFO holds a packet ready to send |
| txn_end | input | 1 | Current data transaction finished (pulse) |
| txn_ack | input | 1 | Host acknowledged the packet; valid with `txn_end` |
| underrun | input | 1 | Transmit FIFO ran empty during the packet (pulse) |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 1 data, 2 NAK, 3 STALL |
| crc_bad | output | 1 | Corrupt the CRC of the outgoing packet |
| fifo_flush | output | 1 | One-cycle transmit FIFO flush request |
| data_pid | output | 1 | Current data toggle (0 = DATA0) |

## Verification
The assertions assume that the protocol side sends no IN token while a data transaction is still open, that `txn_end` and `underrun` arrive only during an open transaction, and that `txn_ack` matters only alongside `txn_end`. They also assume that a hardware setting of the stall-issued flag and a software clear of it never land in the same cycle. The directed tasks keep to these limits. Each task ends a transaction before it sends the next token, and it issues register writes only in cycles with no token. Every strobe is one cycle wide and is driven on the falling edge.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;
   typedef enum logic [1:0] {
      HS_NONE  = 2'd0,
      HS_DATA  = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   localparam int unsigned BIT_DONE  = 0;
   localparam int unsigned BIT_UNDR  = 1;
   localparam int unsigned BIT_SENT  = 2;
   localparam int unsigned BIT_FORCE = 3;
   localparam int unsigned BIT_TOGL  = 4;
   localparam int unsigned FIELD_CNT = 5;
endpackage

// File: rtl/in_ep_stall_ctl.sv
module in_ep_stall_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_force,
   input  logic wr_sent,
   input  logic busy,
   input  logic stall_hs,
   output logic force_q,
   output logic sent_q,
   output logic stalled_q,
   output logic stall_exit,
   output logic flush_q
);
   logic enter;
   logic sent_set;
   logic sent_clr;

   assign enter      = force_q && !busy && !stalled_q;
   assign stall_exit = stalled_q && !force_q && !sent_q;
   assign sent_set   = enter || stall_hs;
   assign sent_clr   = wr_en && wr_sent && sent_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q   <= 1'b0;
         sent_q    <= 1'b0;
         stalled_q <= 1'b0;
         flush_q   <= 1'b0;
      end else begin
         if (wr_en)
            force_q <= wr_force;
         if (sent_set)
            sent_q <= 1'b1;
         else if (sent_clr)
            sent_q <= 1'b0;
         if (enter)
            stalled_q <= 1'b1;
         else if (stall_exit)
            stalled_q <= 1'b0;
         flush_q <= sent_clr && !sent_set;
      end
   end
endmodule

// File: rtl/in_ep_txn.sv
module in_ep_txn
   import in_ep_pkg::*;
#(
   parameter bit HS_PIPE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tok_in,
   input  logic       pkt_ready,
   input  logic       txn_end,
   input  logic       txn_ack,
   input  logic       underrun,
   input  logic       stall_req,
   input  logic       toggle_clr,
   input  logic       done_clr,
   output logic       busy_q,
   output logic       toggle_q,
   output logic       done_q,
   output logic       undr_q,
   output logic       crc_bad_q,
   output logic       stall_hs,
   output logic       hs_valid,
   output logic [1:0] hs_code
);
   hs_e  dec;
   logic cur_ur_q;
   logic grant;
   logic good_end;

   always_comb begin
      if (!tok_in)        dec = HS_NONE;
      else if (stall_req) dec = HS_STALL;
      else if (pkt_ready) dec = HS_DATA;
      else                dec = HS_NAK;
   end

   assign grant    = (dec == HS_DATA);
   assign stall_hs = (dec == HS_STALL);
   assign good_end = txn_end && busy_q && txn_ack && !cur_ur_q && !underrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cur_ur_q  <= 1'b0;
         toggle_q  <= 1'b0;
         done_q    <= 1'b0;
         undr_q    <= 1'b0;
         crc_bad_q <= 1'b0;
      end else begin
         if (grant)        busy_q <= 1'b1;
         else if (txn_end) busy_q <= 1'b0;

         if (grant)                      cur_ur_q <= 1'b0;
         else if (underrun && busy_q)    cur_ur_q <= 1'b1;

         if (toggle_clr)    toggle_q <= 1'b0;
         else if (good_end) toggle_q <= ~toggle_q;

         if (txn_end && busy_q) done_q <= 1'b1;
         else if (done_clr)     done_q <= 1'b0;

         if (underrun && busy_q) undr_q <= 1'b1;
         else if (done_clr)      undr_q <= 1'b0;

         crc_bad_q <= underrun && busy_q;
      end
   end

   generate
      if (HS_PIPE) begin : g_hs_reg
         logic       v_q;
         logic [1:0] c_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_q <= 1'b0;
               c_q <= HS_NONE;
            end else begin
               v_q <= tok_in;
               c_q <= dec;
            end
         end
         assign hs_valid = v_q;
         assign hs_code  = c_q;
      end else begin : g_hs_comb
         assign hs_valid = tok_in;
         assign hs_code  = dec;
      end
   endgenerate
endmodule

// File: rtl/in_ep_ctl.sv
module in_ep_ctl
   import in_ep_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter bit          HS_PIPE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             tok_in,
   input  logic             pkt_ready,
   input  logic             txn_end,
   input  logic             txn_ack,
   input  logic             underrun,
   output logic             hs_valid,
   output logic [1:0]       hs_code,
   output logic             crc_bad,
   output logic             fifo_flush,
   output logic             data_pid
);
   generate
      if (REG_W <= FIELD_CNT) begin : g_bad_width
         $error("in_ep_ctl: REG_W must exceed the field count");
      end
   endgenerate

   logic force_q, sent_q, stalled_q, stall_exit, stall_hs;
   logic busy_q, toggle_q, done_q, undr_q;
   logic unused_wbits;

   assign unused_wbits = ^{reg_wdata[REG_W-1:FIELD_CNT],
                           reg_wdata[BIT_UNDR], reg_wdata[BIT_TOGL]};

   in_ep_stall_ctl u_stall (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .wr_force   (reg_wdata[BIT_FORCE]),
      .wr_sent    (reg_wdata[BIT_SENT]),
      .busy       (busy_q),
      .stall_hs   (stall_hs),
      .force_q    (force_q),
      .sent_q     (sent_q),
      .stalled_q  (stalled_q),
      .stall_exit (stall_exit),
      .flush_q    (fifo_flush)
   );

   in_ep_txn #(.HS_PIPE(HS_PIPE)) u_txn (
      .clk        (clk),
      .rst_n      (rst_n),
      .tok_in     (tok_in),
      .pkt_ready  (pkt_ready),
      .txn_end    (txn_end),
      .txn_ack    (txn_ack),
      .underrun   (underrun),
      .stall_req  (force_q || sent_q || stalled_q),
      .toggle_clr (stall_exit),
      .done_clr   (reg_wr && reg_wdata[BIT_DONE]),
      .busy_q     (busy_q),
      .toggle_q   (toggle_q),
      .done_q     (done_q),
      .undr_q     (undr_q),
      .crc_bad_q  (crc_bad),
      .stall_hs   (stall_hs),
      .hs_valid   (hs_valid),
      .hs_code    (hs_code)
   );

   always_comb begin
      reg_rdata            = '0;
      reg_rdata[BIT_DONE]  = done_q;
      reg_rdata[BIT_UNDR]  = undr_q && done_q;
      reg_rdata[BIT_SENT]  = sent_q;
      reg_rdata[BIT_FORCE] = force_q;
      reg_rdata[BIT_TOGL]  = toggle_q;
   end

   assign data_pid = toggle_q;
endmodule

// File: rtl/in_ep_ctl_chk.sv
module in_ep_ctl_chk
   import in_ep_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter bit          HS_PIPE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_wdata,
   input logic [REG_W-1:0] reg_rdata,
   input logic             tok_in,
   input logic             pkt_ready,
   input logic             txn_end,
   input logic             txn_ack,
   input logic             underrun,
   input logic             hs_valid,
   input logic [1:0]       hs_code,
   input logic             crc_bad,
   input logic             fifo_flush,
   input logic             data_pid
);
   generate
      if (HS_PIPE) begin : g_pipe
         AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_in && (reg_rdata[BIT_FORCE] || reg_rdata[BIT_SENT]))
               |=> (hs_valid && hs_code == HS_STALL)); // R3
      end else begin : g_comb
         AST_STALL_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
            (tok_in && (reg_rdata[BIT_FORCE] || reg_rdata[BIT_SENT]))
               |-> (hs_valid && hs_code == HS_STALL)); // R3
      end
   endgenerate

   AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |=> !fifo_flush); // R5

   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_flush |-> ($past(reg_rdata[BIT_SENT]) && !reg_rdata[BIT_SENT])); // R5

   AST_SENT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[BIT_SENT]) |-> $past(reg_rdata[BIT_FORCE])); // R4

   AST_TOGGLE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(data_pid) |-> ($past(txn_end && txn_ack) || !data_pid)); // R7

   AST_CRC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      crc_bad |-> $past(underrun)); // R8

   AST_UNDR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[BIT_UNDR]) |-> $past(underrun || txn_end)); // R9
endmodule

bind in_ep_ctl in_ep_ctl_chk #(.REG_W(REG_W), .HS_PIPE(HS_PIPE)) u_chk (.*);

// File: tb/in_ep_ctl_test.sv
module in_ep_ctl_test;
   import in_ep_pkg::*;

   localparam int unsigned REG_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             reg_wr = 1'b0;
   logic [REG_W-1:0] reg_wdata = '0;
   logic [REG_W-1:0] reg_rdata;
   logic             tok_in = 1'b0;
   logic             pkt_ready = 1'b0;
   logic             txn_end = 1'b0;
   logic             txn_ack = 1'b0;
   logic             underrun = 1'b0;
   logic             hs_valid;
   logic [1:0]       hs_code;
   logic             crc_bad;
   logic             fifo_flush;
   logic             data_pid;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   in_ep_ctl #(.REG_W(REG_W), .HS_PIPE(1'b1)) uut (.*);

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [REG_W-1:0] d);
      reg_wr = 1'b1;
      reg_wdata = d;
      step();
      reg_wr = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic token(input string req, input int exp_code);
      tok_in = 1'b1;
      step();
      tok_in = 1'b0;
      chk({req, " hs_valid"}, int'(hs_valid), 1);
      chk({req, " hs_code"}, int'(hs_code), exp_code);
      step();
      chk({req, " hs_valid drop"}, int'(hs_valid), 0);
   endtask

   task automatic finish_txn(input logic ack);
      txn_end = 1'b1;
      txn_ack = ack;
      step();
      txn_end = 1'b0;
      txn_ack = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 rdata", int'(reg_rdata), 0);
      chk("R1 data_pid", int'(data_pid), 0);
      chk("R1 outputs", int'({hs_valid, crc_bad, fifo_flush}), 0);
   endtask

   task automatic t_nak_data();
      pkt_ready = 1'b0;
      token("R2 nak", 2);
      chk("R7 toggle after NAK", int'(data_pid), 0);
      pkt_ready = 1'b1;
      token("R2 data", 1);
      finish_txn(1'b1);
      chk("R7 toggle after ack", int'(data_pid), 1);
      chk("R10 done set", int'(reg_rdata[0]), 1);
      wr(8'h01);
      chk("R10 done cleared", int'(reg_rdata[0]), 0);
      token("R2 data no ack", 1);
      finish_txn(1'b0);
      chk("R7 toggle no ack", int'(reg_rdata[4]), 1);
      wr(8'h01);
   endtask

   task automatic t_underrun();
      pkt_ready = 1'b1;
      token("R2 data ur", 1);
      underrun = 1'b1;
      step();
      underrun = 1'b0;
      chk("R8 crc_bad high", int'(crc_bad), 1);
      chk("R9 masked before done", int'(reg_rdata[1]), 0);
      step();
      chk("R8 crc_bad one cycle", int'(crc_bad), 0);
      finish_txn(1'b1);
      chk("R7 toggle kept on underrun", int'(data_pid), 1);
      chk("R9 underrun visible", int'(reg_rdata[1:0]), 3);
      wr(8'h01);
      chk("R9 underrun cleared with done", int'(reg_rdata[1:0]), 0);
   endtask

   task automatic t_stall();
      wr(8'h08);
      chk("R3 force reads 1", int'(reg_rdata[3]), 1);
      chk("R4 sent not yet", int'(reg_rdata[2]), 0);
      step();
      chk("R4 sent at entry", int'(reg_rdata[2]), 1);
      pkt_ready = 1'b1;
      token("R3 stall", 3);
      wr(8'h0C);
      chk("R5 flush pulse", int'(fifo_flush), 1);
      chk("R5 sent cleared", int'(reg_rdata[2]), 0);
      step();
      chk("R5 flush one cycle", int'(fifo_flush), 0);
      tok_in = 1'b1;
      step();
      tok_in = 1'b0;
      chk("R3 stall again", int'(hs_code), 3);
      chk("R5 sent reset by stall hs", int'(reg_rdata[2]), 1);
      wr(8'h00);
      chk("R3 force cleared", int'(reg_rdata[3]), 0);
      chk("R5 write0 no effect", int'(reg_rdata[2]), 1);
      step();
      chk("R6 toggle kept in stall", int'(data_pid), 1);
      token("R6 stall while sent", 3);
      wr(8'h04);
      chk("R5 flush on clear", int'(fifo_flush), 1);
      step();
      chk("R6 toggle reset", int'(data_pid), 0);
      chk("R6 reg reads zero", int'(reg_rdata), 0);
      token("R6 data after exit", 1);
      finish_txn(1'b1);
      chk("R7 toggle after exit ack", int'(data_pid), 1);
      wr(8'h01);
   endtask

   task automatic t_deferred();
      pkt_ready = 1'b1;
      token("R4 data", 1);
      wr(8'h08);
      step();
      step();
      chk("R4 no entry while busy", int'(reg_rdata[2]), 0);
      finish_txn(1'b1);
      chk("R4 no entry at end edge", int'(reg_rdata[2]), 0);
      chk("R7 toggle flipped", int'(data_pid), 0);
      step();
      chk("R4 entry after idle", int'(reg_rdata[2]), 1);
      token("R3 stall deferred", 3);
      wr(8'h00);
      wr(8'h04);
      step();
      chk("R6 exit clean", int'(reg_rdata[4:2]), 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      step();
      step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_nak_data();
      t_underrun();
      t_stall();
      t_deferred();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule